// File: doc/BRIEF.md
# ADC Channel Scan Sequencer

This block drives an eight-input analog-to-digital converter core through a range of channels. Software programs a first channel, a last channel, an operating mode and which hardware trigger sources are allowed. When an accepted trigger arrives, the sequencer captures that setup. It then asks the converter core for one conversion at a time, using a start pulse and a done pulse, and moves to the next channel after each done.

The channel range may wrap. If the first channel is numbered higher than the last, the scan goes up to the top channel, continues from channel 0, and stops at the last channel. There are four modes:
- A one-pass mode that a new trigger can restart.
- A one-pass mode that ignores triggers.
- A looping mode.
- A stepping mode that converts one channel per trigger.

The looping and stepping modes run until software clears busy. A readback port shows the channel in progress. While stepping is paused, it shows the channel converted most recently. While idle, it shows the programmed first channel.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, `busy`, `conv_start`, `ch_done` and `scan_done` are 0.
- R2: A `sw_start` pulse is always a trigger. `src_sel` bit 0 enables `tmr_trig` and bit 1 enables `ext_trig`. A pulse on a disabled source does not start a scan.
- R3: `cfg_mode` 00 (one-pass, restartable) converts each channel from first to last once. `busy` then falls together with a `scan_done` pulse.
- R4: In mode 00, a trigger during a conversion abandons it and starts the scan again from the first channel.
- R5: `cfg_mode` 01 (one-pass, locked) converts first to last once. Triggers while busy have no effect on the channel order.
- R6: When first > last, the order is first, first+1, ..., 7, 0, ..., last.
- R7: When first == last, exactly one conversion of that channel is made per pass.
- R8: `cfg_mode` 10 (loop) returns to the first channel after the last channel and keeps converting. Triggers while busy do not disturb the order.
- R9: `cfg_mode` 11 (step) converts one channel per accepted trigger and pauses with `busy` high in between. After the last channel, the next trigger converts the first channel.
- R10: `cur_ch` shows the channel being converted while busy, the most recently converted channel while paused, and `cfg_first_ch` while idle.
- R11: The mode, first channel and last channel are captured when a scan begins. Later changes to `cfg_*` do not alter that scan.
- R12: A `busy_clr` pulse forces `busy` low on the next cycle, and no `conv_start` follows.
- R13: Every `conv_done` in a scan gives one single-cycle `ch_done`. The done of the last channel also gives `scan_done` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 2 | Mode: 00 one-pass restartable, 01 one-pass locked, 10 loop, 11 step |
| cfg_first_ch | input | CH_W | First channel of the range |
| cfg_last_ch | input | CH_W | Last channel of the range |
| src_sel | input | 2 | Bit 0 enables the timer trigger, bit 1 enables the external trigger |
| sw_start | input | 1 | Software trigger pulse |
| tmr_trig | input | 1 | Timer trigger pulse |
| ext_trig | input | 1 | External trigger (pulse, or level with edge detection when EXT_EDGE=1) |
| busy_clr | input | 1 | Software forced-stop pulse |
| conv_start | output | 1 | One-cycle conversion request to the converter core |
| conv_ch | output | CH_W | Channel for the requested conversion |
| conv_done | input | 1 | Conversion-complete pulse from the core |
| busy | output | 1 | Scan active, including paused in step mode |
| cur_ch | output | CH_W | Channel readback |
| ch_done | output | 1 | One-cycle pulse per completed channel |
| scan_done | output | 1 | One-cycle pulse when the last channel completes |

## Verification
The hardest situation to reach is a restart that lands while a conversion is still in flight. This shows whether the abandoned conversion leaks a `ch_done` or skips a channel. The bench waits until the monitor has logged a request for the second channel. It then fires a software trigger inside the core's latency window, and expects the logged order to restart from the first channel with no done counted for the abandoned one. A forced stop in loop mode with a conversion in flight is reached the same way. The late done from the core must then be ignored.

// File: rtl/adc_scan_pkg.sv
`timescale 1ns/1ps
package adc_scan_pkg;

   typedef enum logic [1:0] {
      MODE_ONCE_RESTART = 2'b00,
      MODE_ONCE_LOCKED  = 2'b01,
      MODE_LOOP         = 2'b10,
      MODE_STEP         = 2'b11
   } scan_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'b00,
      ST_CONV  = 2'b01,
      ST_PAUSE = 2'b10
   } seq_state_e;

endpackage

// File: rtl/adc_trig_sel.sv
`timescale 1ns/1ps
module adc_trig_sel (
   input  logic       sw_start,
   input  logic       tmr_evt,
   input  logic       ext_evt,
   input  logic [1:0] src_sel,
   output logic       trig_hit
);
   // Software is always a source; hardware sources are gated by src_sel.
   always_comb begin
      trig_hit = sw_start
               | (tmr_evt & src_sel[0])
               | (ext_evt & src_sel[1]);
   end
endmodule

// File: rtl/adc_ch_step.sv
`timescale 1ns/1ps
module adc_ch_step #(
   parameter int NUM_CH = 8,
   localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic [CH_W-1:0] cur,
   input  logic [CH_W-1:0] last,
   input  logic [CH_W-1:0] first,
   output logic [CH_W-1:0] nxt,
   output logic            at_end
);
   logic [CH_W-1:0] inc;

   generate
      if (NUM_CH == (1 << CH_W)) begin : g_pow2
         // Natural roll-over of the counter gives the wrap to channel 0.
         always_comb inc = cur + CH_W'(1);
      end else begin : g_npow2
         always_comb inc = (cur == CH_W'(NUM_CH - 1)) ? '0 : cur + CH_W'(1);
      end
   endgenerate

   always_comb begin
      at_end = (cur == last);
      nxt    = at_end ? first : inc;
   end
endmodule

// File: rtl/adc_scan_seq.sv
`timescale 1ns/1ps
module adc_scan_seq
   import adc_scan_pkg::*;
#(
   parameter int NUM_CH   = 8,
   parameter bit EXT_EDGE = 1'b0,
   localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [1:0]      cfg_mode,
   input  logic [CH_W-1:0] cfg_first_ch,
   input  logic [CH_W-1:0] cfg_last_ch,
   input  logic [1:0]      src_sel,
   input  logic            sw_start,
   input  logic            tmr_trig,
   input  logic            ext_trig,
   input  logic            busy_clr,
   output logic            conv_start,
   output logic [CH_W-1:0] conv_ch,
   input  logic            conv_done,
   output logic            busy,
   output logic [CH_W-1:0] cur_ch,
   output logic            ch_done,
   output logic            scan_done
);

   generate
      if (NUM_CH < 2) begin : g_bad_nch
         $error("adc_scan_seq: NUM_CH must be at least 2");
      end
   endgenerate

   seq_state_e      state_q;
   scan_mode_e      mode_q;
   logic [CH_W-1:0] ch_q, first_q, last_q;
   logic            start_q, chd_q, scd_q;
   logic            ext_evt, trig_hit;
   logic [CH_W-1:0] ch_nxt;
   logic            ch_at_end;
   logic            is_once;

   // External trigger: pulse input or level input with rising-edge detection.
   generate
      if (EXT_EDGE) begin : g_ext_edge
         logic ext_d;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ext_d <= 1'b0;
            else        ext_d <= ext_trig;
         end
         always_comb ext_evt = ext_trig & ~ext_d;
      end else begin : g_ext_pulse
         always_comb ext_evt = ext_trig;
      end
   endgenerate

   adc_trig_sel u_trig (
      .sw_start (sw_start),
      .tmr_evt  (tmr_trig),
      .ext_evt  (ext_evt),
      .src_sel  (src_sel),
      .trig_hit (trig_hit)
   );

   adc_ch_step #(.NUM_CH(NUM_CH)) u_step (
      .cur    (ch_q),
      .last   (last_q),
      .first  (first_q),
      .nxt    (ch_nxt),
      .at_end (ch_at_end)
   );

   always_comb is_once = (mode_q == MODE_ONCE_RESTART) || (mode_q == MODE_ONCE_LOCKED);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         mode_q  <= MODE_ONCE_RESTART;
         ch_q    <= '0;
         first_q <= '0;
         last_q  <= '0;
         start_q <= 1'b0;
         chd_q   <= 1'b0;
         scd_q   <= 1'b0;
      end else begin
         start_q <= 1'b0;
         chd_q   <= 1'b0;
         scd_q   <= 1'b0;
         if (busy_clr) begin
            state_q <= ST_IDLE;
         end else begin
            unique case (state_q)
               ST_IDLE: begin
                  if (trig_hit) begin
                     mode_q  <= scan_mode_e'(cfg_mode);
                     first_q <= cfg_first_ch;
                     last_q  <= cfg_last_ch;
                     ch_q    <= cfg_first_ch;
                     state_q <= ST_CONV;
                     start_q <= 1'b1;
                  end
               end
               ST_CONV: begin
                  if (trig_hit && mode_q == MODE_ONCE_RESTART) begin
                     // Restart: a new scan begins, so setup is captured again.
                     mode_q  <= scan_mode_e'(cfg_mode);
                     first_q <= cfg_first_ch;
                     last_q  <= cfg_last_ch;
                     ch_q    <= cfg_first_ch;
                     start_q <= 1'b1;
                  end else if (conv_done) begin
                     chd_q <= 1'b1;
                     scd_q <= ch_at_end;
                     if (mode_q == MODE_STEP) begin
                        state_q <= ST_PAUSE;
                     end else if (is_once && ch_at_end) begin
                        state_q <= ST_IDLE;
                     end else begin
                        ch_q    <= ch_nxt;
                        start_q <= 1'b1;
                     end
                  end
               end
               ST_PAUSE: begin
                  if (trig_hit) begin
                     ch_q    <= ch_nxt;
                     state_q <= ST_CONV;
                     start_q <= 1'b1;
                  end
               end
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end

   always_comb begin
      busy       = (state_q != ST_IDLE);
      cur_ch     = busy ? ch_q : cfg_first_ch;
      conv_ch    = ch_q;
      conv_start = start_q;
      ch_done    = chd_q;
      scan_done  = scd_q;
   end

endmodule

// File: rtl/adc_scan_seq_chk.sv
`timescale 1ns/1ps
module adc_scan_seq_chk #(
   parameter int CH_W = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic            sw_start,
   input logic            tmr_trig,
   input logic            ext_trig,
   input logic            busy_clr,
   input logic            conv_start,
   input logic            conv_done,
   input logic            busy,
   input logic [CH_W-1:0] cur_ch,
   input logic            ch_done,
   input logic            scan_done
);

   assert_start_when_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> busy);

   assert_clr_stops_R12: assert property (@(posedge clk) disable iff (!rst_n)
      busy_clr |=> (!busy && !conv_start));

   assert_fall_on_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (scan_done || $past(busy_clr)));

   assert_scan_with_ch_R13: assert property (@(posedge clk) disable iff (!rst_n)
      scan_done |-> ch_done);

   assert_chdone_from_core_R13: assert property (@(posedge clk) disable iff (!rst_n)
      ch_done |-> $past(conv_done));

   assert_ch_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !$past(conv_done)
       && !$past(sw_start || tmr_trig || ext_trig)) |-> $stable(cur_ch));

endmodule

bind adc_scan_seq adc_scan_seq_chk #(.CH_W(CH_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sw_start   (sw_start),
   .tmr_trig   (tmr_trig),
   .ext_trig   (ext_trig),
   .busy_clr   (busy_clr),
   .conv_start (conv_start),
   .conv_done  (conv_done),
   .busy       (busy),
   .cur_ch     (cur_ch),
   .ch_done    (ch_done),
   .scan_done  (scan_done)
);

// File: tb/adc_scan_seq_tb.sv
`timescale 1ns/1ps
module adc_scan_seq_tb;
   localparam int NCH = 8;
   localparam int CW  = 3;
   localparam int LAT = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    cfg_mode = 2'b00;
   logic [CW-1:0] cfg_first_ch = '0;
   logic [CW-1:0] cfg_last_ch = '0;
   logic [1:0]    src_sel = 2'b00;
   logic          sw_start = 1'b0, tmr_trig = 1'b0, ext_trig = 1'b0, busy_clr = 1'b0;
   logic          conv_start, conv_done = 1'b0, busy, ch_done, scan_done;
   logic [CW-1:0] conv_ch, cur_ch;

   int n_tests = 0, n_fail = 0;
   int logch [0:255];
   int nlog = 0, n_chd = 0, n_scd = 0, core_cnt = 0;

   always #2.5 clk = ~clk;

   adc_scan_seq #(.NUM_CH(NCH)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_first_ch(cfg_first_ch),
      .cfg_last_ch(cfg_last_ch), .src_sel(src_sel), .sw_start(sw_start),
      .tmr_trig(tmr_trig), .ext_trig(ext_trig), .busy_clr(busy_clr),
      .conv_start(conv_start), .conv_ch(conv_ch), .conv_done(conv_done),
      .busy(busy), .cur_ch(cur_ch), .ch_done(ch_done), .scan_done(scan_done)
   );

   // Converter core model and pulse monitor; a new start abandons any conversion.
   always @(negedge clk) begin
      conv_done = 1'b0;
      if (conv_start) begin
         if (nlog < 256) logch[nlog] = int'(conv_ch);
         nlog++;
         core_cnt = LAT;
      end else if (core_cnt > 0) begin
         core_cnt--;
         if (core_cnt == 0) conv_done = 1'b1;
      end
      if (ch_done)   n_chd++;
      if (scan_done) n_scd++;
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   // which: 0 software, 1 timer, 2 external, 3 forced stop
   task automatic pulse(input int which);
      @(negedge clk); #1;
      case (which)
         0: sw_start = 1'b1;
         1: tmr_trig = 1'b1;
         2: ext_trig = 1'b1;
         default: busy_clr = 1'b1;
      endcase
      @(negedge clk); #1;
      sw_start = 1'b0; tmr_trig = 1'b0; ext_trig = 1'b0; busy_clr = 1'b0;
   endtask

   task automatic setup(input logic [1:0] m, input int f, input int l, input logic [1:0] s);
      cfg_mode = m; cfg_first_ch = CW'(f); cfg_last_ch = CW'(l); src_sel = s;
      nlog = 0; n_chd = 0; n_scd = 0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 500 && busy; i++) idle(1);
      idle(LAT + 2);
   endtask

   task automatic wait_nlog(input int n);
      for (int i = 0; i < 500 && nlog < n; i++) idle(1);
   endtask

   // Expected order computed from first/last with wrap and loop-back.
   task automatic chk_order(input string tag, input int f, input int l, input int off, input int cnt);
      int c = f;
      for (int k = 0; k < cnt; k++) begin
         chk(tag, logch[off + k], c);
         c = (c == l) ? f : (c + 1) % NCH;
      end
   endtask

   task automatic t_reset();
      cfg_first_ch = 3'd4;
      idle(1);
      chk("R1 busy after reset", int'(busy), 0);
      chk("R1 conv_start after reset", int'(conv_start), 0);
      chk("R1 pulses after reset", int'(ch_done | scan_done), 0);
      chk("R10 idle readback", int'(cur_ch), 4);
   endtask

   task automatic t_once();
      setup(2'b00, 1, 5, 2'b00);
      pulse(0);
      chk("R10 cur_ch while converting", int'(cur_ch), 1);
      wait_idle();
      chk("R3 conversions", nlog, 5);
      chk_order("R3 order", 1, 5, 0, 5);
      chk("R3 scan_done count", n_scd, 1);
      chk("R13 ch_done count", n_chd, 5);
      chk("R3 busy low", int'(busy), 0);
      cfg_first_ch = 3'd6; idle(1);
      chk("R10 idle readback follows cfg", int'(cur_ch), 6);
   endtask

   task automatic t_restart();
      setup(2'b00, 1, 5, 2'b00);
      pulse(0);
      wait_nlog(2);
      pulse(0);
      wait_idle();
      chk("R4 conversions", nlog, 7);
      chk_order("R4 first part", 1, 5, 0, 2);
      chk_order("R4 restarted part", 1, 5, 2, 5);
      chk("R4 abandoned not counted R13", n_chd, 6);
      chk("R4 scan_done", n_scd, 1);
   endtask

   task automatic t_locked();
      setup(2'b01, 1, 5, 2'b00);
      pulse(0);
      wait_nlog(2);
      pulse(0);
      wait_idle();
      chk("R5 conversions", nlog, 5);
      chk_order("R5 order", 1, 5, 0, 5);
      chk("R5 scan_done", n_scd, 1);
   endtask

   task automatic t_wrap();
      setup(2'b01, 6, 2, 2'b00);
      pulse(0);
      wait_idle();
      chk("R6 conversions", nlog, 5);
      chk_order("R6 order", 6, 2, 0, 5);
   endtask

   task automatic t_single_ch();
      setup(2'b00, 2, 2, 2'b00);
      pulse(0);
      wait_idle();
      chk("R7 conversions", nlog, 1);
      chk("R7 channel", logch[0], 2);
      chk("R7 scan_done", n_scd, 1);
   endtask

   task automatic t_capture();
      setup(2'b01, 1, 3, 2'b00);
      pulse(0);
      cfg_first_ch = 3'd5; cfg_last_ch = 3'd7; cfg_mode = 2'b10;
      wait_idle();
      chk("R11 conversions", nlog, 3);
      chk_order("R11 order", 1, 3, 0, 3);
   endtask

   task automatic t_src();
      setup(2'b00, 0, 0, 2'b10);
      pulse(1);
      idle(4);
      chk("R2 timer disabled", int'(busy), 0);
      chk("R2 no request", nlog, 0);
      pulse(2);
      chk("R2 external enabled", int'(busy), 1);
      wait_idle();
      src_sel = 2'b01;
      pulse(2);
      idle(4);
      chk("R2 external disabled", nlog, 1);
      pulse(1);
      wait_idle();
      chk("R2 timer enabled", nlog, 2);
   endtask

   task automatic t_loop();
      int snap;
      setup(2'b10, 6, 1, 2'b11);
      pulse(0);
      wait_nlog(6);
      pulse(1);
      pulse(0);
      wait_nlog(10);
      pulse(3);
      chk("R12 busy cleared", int'(busy), 0);
      snap = nlog;
      chk_order("R8 loop order", 6, 1, 0, snap);
      chk("R8 scan_done repeats", int'(n_scd >= 2), 1);
      idle(12);
      chk("R12 no request after stop", nlog, snap);
      chk("R12 busy stays low", int'(busy), 0);
   endtask

   task automatic t_step();
      setup(2'b11, 3, 4, 2'b01);
      pulse(1);
      idle(10);
      chk("R9 one conversion", nlog, 1);
      chk("R9 busy while paused", int'(busy), 1);
      chk("R10 paused readback", int'(cur_ch), 3);
      chk("R13 ch_done", n_chd, 1);
      chk("R9 no scan_done yet", n_scd, 0);
      pulse(1);
      idle(10);
      chk("R9 second channel", logch[1], 4);
      chk("R10 paused readback 2", int'(cur_ch), 4);
      chk("R13 scan_done at last", n_scd, 1);
      pulse(1);
      idle(10);
      chk("R9 back to first", logch[2], 3);
      chk("R9 count", nlog, 3);
      pulse(3);
      idle(2);
      chk("R12 stop from pause", int'(busy), 0);
   endtask

   initial begin
      #(5.0 * 150000);
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      t_reset();
      t_once();
      t_restart();
      t_locked();
      t_wrap();
      t_single_ch();
      t_capture();
      t_src();
      t_loop();
      t_step();
      summary();
      $finish;
   end
endmodule